// File: doc/BRIEF.md
# Request Legality Guard for a Lightweight Split-Transaction Bus

This block sits directly in front of a bus completer on a 32-bit data path with separate request and response channels, each using a valid/ready handshake. Every host request is examined in the cycle it is presented: its opcode, its transfer size, the low address bits and the byte-lane mask. A request that passes every rule goes to the completer without delay and without change, and completer responses return to the host unchanged.

A request that breaks any rule never reaches the completer. The guard takes it from the host and stores its ID and its kind, then answers with its own error response. Until that answer has been taken, the guard stalls the host. It also holds the answer back until every request already forwarded has had its response, so the host receives responses in the order it issued the requests. A small counter tracks how many forwarded requests are still outstanding, and forwarding stops when the counter reaches its limit.

Top module: `tlreq_guard`

## Requirements
- R1: A request opcode of 0 (full write), 1 (partial write) or 4 (read) is legal. Any other opcode value (2, 3, 5, 6, 7) makes the request illegal.
- R2: The size field gives log2 of the byte count. A size greater than 2 makes the request illegal.
- R3: A request whose address low bits are not a multiple of the transfer byte count is illegal. Example: size 1 with address bit 0 set.
- R4: Mask bit i belongs to byte lane i. The active lanes run from the lane selected by address bits [1:0] up through the transfer byte count. Any mask bit set outside the active lanes makes the request illegal.
- R5: A full write (opcode 0) whose mask does not set every active lane is illegal.
- R6: With CONTIG_ONLY=1 (the default), only masks 0000, 0001, 0010, 0100, 1000, 0011, 0110, 1100, 0111, 1110 and 1111 are allowed. Any other mask makes the request illegal.
- R7: A legal request appears on the device request port in the same cycle, with every field unchanged. In that case the host ready equals the device ready.
- R8: An illegal request is accepted from the host. It then produces exactly one host response with these values: error bit 1, ID equal to the request ID, data zero, and response opcode 1 for a read request or 0 for any other request. The response fields stay stable while the host holds ready low.
- R9: The error response first appears no earlier than the cycle after the illegal request is accepted. From that acceptance until the error response is taken, the host ready stays low and nothing is forwarded.
- R10: Device responses pass to the host unchanged, error bit included, with device ready equal to host ready. A pending error response waits until every forwarded request has been answered.
- R11: When MAX_OUT forwarded requests are outstanding (default 4), no further request is forwarded or accepted until one response returns.
- R12: Reset is synchronous and active low. It clears any pending error response and the outstanding count, so no host response or device request appears afterwards without new stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| hreq_valid_i | input | 1 | Host request valid |
| hreq_ready_o | output | 1 | Host request accepted |
| hreq_op_i | input | 3 | Host request opcode |
| hreq_size_i | input | SZW (2) | Host request size, log2 bytes |
| hreq_addr_i | input | AW (32) | Host request address |
| hreq_id_i | input | IDW (8) | Host request ID |
| hreq_mask_i | input | DW/8 (4) | Host request byte-lane mask |
| hreq_data_i | input | DW (32) | Host write data |
| hrsp_valid_o | output | 1 | Host response valid |
| hrsp_ready_i | input | 1 | Host response accepted |
| hrsp_op_o | output | 3 | Host response opcode |
| hrsp_err_o | output | 1 | Host response error bit |
| hrsp_id_o | output | IDW (8) | Host response ID |
| hrsp_data_o | output | DW (32) | Host response read data |
| dreq_valid_o | output | 1 | Device request valid |
| dreq_ready_i | input | 1 | Device request accepted |
| dreq_op_o | output | 3 | Device request opcode |
| dreq_size_o | output | SZW (2) | Device request size |
| dreq_addr_o | output | AW (32) | Device request address |
| dreq_id_o | output | IDW (8) | Device request ID |
| dreq_mask_o | output | DW/8 (4) | Device request mask |
| dreq_data_o | output | DW (32) | Device request write data |
| drsp_valid_i | input | 1 | Device response valid |
| drsp_ready_o | output | 1 | Device response accepted |
| drsp_op_i | input | 3 | Device response opcode |
| drsp_err_i | input | 1 | Device response error bit |
| drsp_id_i | input | IDW (8) | Device response ID |
| drsp_data_i | input | DW (32) | Device response read data |

## Verification
The bench sends each kind of illegal request: masks with a gap such as 1001 and 0101, a full write with one lane missing, an upper-lane mask on a byte access, a size of 3, a misaligned halfword and undefined opcodes. A guard that checked too little would pass such a request on to the device. One that checked too much would return an error where the device should have answered. In one case an illegal request arrives while two reads are still outstanding. A guard that ignored in-flight traffic would return its error ahead of older responses, which breaks ordering. The outstanding limit is filled to the last slot; an off-by-one in the counter would either forward a fifth request or stall on the fourth. A reset with an error still pending checks that no stale response survives the reset.

// File: rtl/tlreq_guard_pkg.sv
// Package: opcode values and response opcode selection shared by the guard.
// Assumes the standard lightweight-bus opcode space of three bits.
package tlreq_guard_pkg;

    localparam logic [2:0] REQ_WRITE_ALL  = 3'd0;
    localparam logic [2:0] REQ_WRITE_SOME = 3'd1;
    localparam logic [2:0] REQ_READ       = 3'd4;

    localparam logic [2:0] RSP_ACK        = 3'd0;
    localparam logic [2:0] RSP_ACK_DATA   = 3'd1;

    // Response opcode that answers a request of the given kind.
    function automatic logic [2:0] rsp_op_for(input logic is_read);
        return is_read ? RSP_ACK_DATA : RSP_ACK;
    endfunction

endpackage

// File: rtl/tlreq_legal_chk.sv
// Module: combinational legality check for one request.
// Computes the active byte lanes from the address low bits and the size,
// then applies the opcode, size, alignment, lane, full-write and optional
// contiguity rules. Assumes DW is a power of two of at least 16 bits.
module tlreq_legal_chk #(
    parameter int DW          = 32,
    parameter bit CONTIG_ONLY = 1'b1,
    localparam int LANES      = DW / 8,
    localparam int LG         = $clog2(LANES),
    localparam int SZW        = $clog2(LG + 1)
) (
    input  logic [2:0]       op_i,
    input  logic [SZW-1:0]   size_i,
    input  logic [LG-1:0]    addr_lo_i,
    input  logic [LANES-1:0] mask_i,
    output logic             legal_o
);
    import tlreq_guard_pkg::*;

    localparam int LGW = LG + 2;

    logic [LGW-1:0]   span;
    logic [LGW-1:0]   lo_ext;
    logic [LGW-1:0]   hi_ext;
    logic [LGW-1:0]   low_sel;
    logic [LANES-1:0] lane_on;
    logic             op_bad;
    logic             size_bad;
    logic             align_bad;
    logic             lane_bad;
    logic             full_bad;
    logic             gap_bad;

    // Byte count and lane window covered by the access.
    always_comb begin
        span    = LGW'(1) << size_i;
        lo_ext  = LGW'(addr_lo_i);
        hi_ext  = lo_ext + span;
        low_sel = span - LGW'(1);
    end

    // One comparator pair per byte lane marks the lanes inside the window.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_on[i] = (LGW'(i) >= lo_ext) && (LGW'(i) < hi_ext);
    end

    // Individual rule violations.
    always_comb begin
        op_bad    = !(op_i == REQ_WRITE_ALL || op_i == REQ_WRITE_SOME || op_i == REQ_READ);
        size_bad  = size_i > SZW'(LG);
        align_bad = |(addr_lo_i & low_sel[LG-1:0]);
        lane_bad  = |(mask_i & ~lane_on);
        full_bad  = (op_i == REQ_WRITE_ALL) && ((mask_i & lane_on) != lane_on);
    end

    // Contiguity: adding the lowest set bit clears a single run of ones.
    if (CONTIG_ONLY) begin : g_contig
        logic [LANES-1:0] low_bit;
        logic [LANES-1:0] carried;
        always_comb begin
            low_bit = mask_i & (~mask_i + LANES'(1));
            carried = mask_i + low_bit;
            gap_bad = |(carried & mask_i);
        end
    end else begin : g_any_mask
        assign gap_bad = 1'b0;
    end

    // Overall verdict.
    assign legal_o = !(op_bad || size_bad || align_bad || lane_bad || full_bad || gap_bad);

endmodule

// File: rtl/tlreq_inflight_ctr.sv
// Module: counts forwarded requests still waiting for a device response.
// Assumes the parent blocks increments at the limit and the device never
// returns a response that was not requested.
module tlreq_inflight_ctr #(
    parameter int MAX_OUT = 4,
    localparam int CW     = $clog2(MAX_OUT + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic inc_i,
    input  logic dec_i,
    output logic idle_o,
    output logic full_o
);
    logic [CW-1:0] cnt_q;

    // Track issue and return events; both in one cycle leave the count as is.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            case ({inc_i, dec_i})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign idle_o = (cnt_q == '0);
    assign full_o = (cnt_q == CW'(MAX_OUT));

    // R11
    ctr_no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        full_o |-> !inc_i);

    // R10
    ctr_no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        idle_o |-> !dec_i);

endmodule

// File: rtl/tlreq_err_slot.sv
// Module: one-entry store for a locally generated error response.
// Holds the ID and the request kind from capture until the host takes it.
// Assumes the parent never captures while an entry is pending.
module tlreq_err_slot #(
    parameter int IDW = 8
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           capture_i,
    input  logic [IDW-1:0] cap_id_i,
    input  logic           cap_read_i,
    input  logic           take_i,
    output logic           pend_o,
    output logic [IDW-1:0] id_o,
    output logic [2:0]     op_o
);
    import tlreq_guard_pkg::*;

    logic           pend_q;
    logic [IDW-1:0] id_q;
    logic           read_q;

    // Fill on capture, empty once the host has taken the response.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pend_q <= 1'b0;
            id_q   <= '0;
            read_q <= 1'b0;
        end else if (capture_i) begin
            pend_q <= 1'b1;
            id_q   <= cap_id_i;
            read_q <= cap_read_i;
        end else if (take_i) begin
            pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;
    assign id_o   = id_q;
    assign op_o   = rsp_op_for(read_q);

    // R9
    no_capture_while_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pend_q |-> !capture_i);

    // R8
    err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_q && !take_i) |=> (pend_q && $stable(id_q) && $stable(read_q)));

endmodule

// File: rtl/tlreq_guard.sv
// Module: top of the request legality guard.
// Forwards legal requests combinationally and answers illegal ones locally.
// A pending error response stalls the host and waits for all forwarded
// requests to be answered. Assumes the device answers in order.
module tlreq_guard #(
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int IDW         = 8,
    parameter int MAX_OUT     = 4,
    parameter bit CONTIG_ONLY = 1'b1,
    localparam int LANES      = DW / 8,
    localparam int LG         = $clog2(LANES),
    localparam int SZW        = $clog2(LG + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hreq_valid_i,
    output logic             hreq_ready_o,
    input  logic [2:0]       hreq_op_i,
    input  logic [SZW-1:0]   hreq_size_i,
    input  logic [AW-1:0]    hreq_addr_i,
    input  logic [IDW-1:0]   hreq_id_i,
    input  logic [LANES-1:0] hreq_mask_i,
    input  logic [DW-1:0]    hreq_data_i,
    output logic             hrsp_valid_o,
    input  logic             hrsp_ready_i,
    output logic [2:0]       hrsp_op_o,
    output logic             hrsp_err_o,
    output logic [IDW-1:0]   hrsp_id_o,
    output logic [DW-1:0]    hrsp_data_o,
    output logic             dreq_valid_o,
    input  logic             dreq_ready_i,
    output logic [2:0]       dreq_op_o,
    output logic [SZW-1:0]   dreq_size_o,
    output logic [AW-1:0]    dreq_addr_o,
    output logic [IDW-1:0]   dreq_id_o,
    output logic [LANES-1:0] dreq_mask_o,
    output logic [DW-1:0]    dreq_data_o,
    input  logic             drsp_valid_i,
    output logic             drsp_ready_o,
    input  logic [2:0]       drsp_op_i,
    input  logic             drsp_err_i,
    input  logic [IDW-1:0]   drsp_id_i,
    input  logic [DW-1:0]    drsp_data_i
);
    import tlreq_guard_pkg::*;

    logic           legal;
    logic           idle;
    logic           full;
    logic           err_pend;
    logic [IDW-1:0] err_id;
    logic [2:0]     err_op;
    logic           err_show;
    logic           capture;
    logic           take;
    logic           inc;
    logic           dec;

    tlreq_legal_chk #(
        .DW          (DW),
        .CONTIG_ONLY (CONTIG_ONLY)
    ) legal_i (
        .op_i      (hreq_op_i),
        .size_i    (hreq_size_i),
        .addr_lo_i (hreq_addr_i[LG-1:0]),
        .mask_i    (hreq_mask_i),
        .legal_o   (legal)
    );

    tlreq_inflight_ctr #(
        .MAX_OUT (MAX_OUT)
    ) ctr_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .inc_i  (inc),
        .dec_i  (dec),
        .idle_o (idle),
        .full_o (full)
    );

    tlreq_err_slot #(
        .IDW (IDW)
    ) slot_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .capture_i  (capture),
        .cap_id_i   (hreq_id_i),
        .cap_read_i (hreq_op_i == REQ_READ),
        .take_i     (take),
        .pend_o     (err_pend),
        .id_o       (err_id),
        .op_o       (err_op)
    );

    // Request side: forward legal requests, absorb illegal ones.
    always_comb begin
        dreq_valid_o = hreq_valid_i && legal && !err_pend && !full;
        if (err_pend)   hreq_ready_o = 1'b0;
        else if (legal) hreq_ready_o = !full && dreq_ready_i;
        else            hreq_ready_o = 1'b1;
        capture = hreq_valid_i && hreq_ready_o && !legal;
        inc     = dreq_valid_o && dreq_ready_i;
    end

    assign dreq_op_o   = hreq_op_i;
    assign dreq_size_o = hreq_size_i;
    assign dreq_addr_o = hreq_addr_i;
    assign dreq_id_o   = hreq_id_i;
    assign dreq_mask_o = hreq_mask_i;
    assign dreq_data_o = hreq_data_i;

    // Response side: the local error waits until the device side is drained.
    always_comb begin
        err_show     = err_pend && idle;
        hrsp_valid_o = err_show || drsp_valid_i;
        hrsp_op_o    = err_show ? err_op : drsp_op_i;
        hrsp_err_o   = err_show ? 1'b1 : drsp_err_i;
        hrsp_id_o    = err_show ? err_id : drsp_id_i;
        hrsp_data_o  = err_show ? '0 : drsp_data_i;
        drsp_ready_o = !err_show && hrsp_ready_i;
        take         = err_show && hrsp_ready_i;
        dec          = drsp_valid_i && drsp_ready_o;
    end

    // R9
    block_while_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_pend |-> !hreq_ready_o);

    // R9
    err_follows_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hreq_valid_i && hreq_ready_o && !legal) |=> err_pend);

    // R7
    fwd_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dreq_valid_o |-> (hreq_ready_o == dreq_ready_i));

    // R10
    rsp_passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drsp_valid_i && drsp_ready_o) |-> (hrsp_valid_o && hrsp_id_o == drsp_id_i
                                            && hrsp_err_o == drsp_err_i));

endmodule

// File: tb/tlreq_guard_tb.sv
// Bench: seeded random requests plus directed corner cases, scored
// against a legality model written from the requirements.
module tlreq_guard_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        hreq_valid_i = 1'b0;
    logic        hreq_ready_o;
    logic [2:0]  hreq_op_i = '0;
    logic [1:0]  hreq_size_i = '0;
    logic [31:0] hreq_addr_i = '0;
    logic [7:0]  hreq_id_i = '0;
    logic [3:0]  hreq_mask_i = '0;
    logic [31:0] hreq_data_i = '0;
    logic        hrsp_valid_o;
    logic        hrsp_ready_i = 1'b0;
    logic [2:0]  hrsp_op_o;
    logic        hrsp_err_o;
    logic [7:0]  hrsp_id_o;
    logic [31:0] hrsp_data_o;
    logic        dreq_valid_o;
    logic        dreq_ready_i = 1'b0;
    logic [2:0]  dreq_op_o;
    logic [1:0]  dreq_size_o;
    logic [31:0] dreq_addr_o;
    logic [7:0]  dreq_id_o;
    logic [3:0]  dreq_mask_o;
    logic [31:0] dreq_data_o;
    logic        drsp_valid_i = 1'b0;
    logic        drsp_ready_o;
    logic [2:0]  drsp_op_i = '0;
    logic        drsp_err_i = 1'b0;
    logic [7:0]  drsp_id_i = '0;
    logic [31:0] drsp_data_i = '0;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tlreq_guard dut_i (
        .clk_i(clk), .rst_ni(rst_ni),
        .hreq_valid_i(hreq_valid_i), .hreq_ready_o(hreq_ready_o),
        .hreq_op_i(hreq_op_i), .hreq_size_i(hreq_size_i), .hreq_addr_i(hreq_addr_i),
        .hreq_id_i(hreq_id_i), .hreq_mask_i(hreq_mask_i), .hreq_data_i(hreq_data_i),
        .hrsp_valid_o(hrsp_valid_o), .hrsp_ready_i(hrsp_ready_i), .hrsp_op_o(hrsp_op_o),
        .hrsp_err_o(hrsp_err_o), .hrsp_id_o(hrsp_id_o), .hrsp_data_o(hrsp_data_o),
        .dreq_valid_o(dreq_valid_o), .dreq_ready_i(dreq_ready_i), .dreq_op_o(dreq_op_o),
        .dreq_size_o(dreq_size_o), .dreq_addr_o(dreq_addr_o), .dreq_id_o(dreq_id_o),
        .dreq_mask_o(dreq_mask_o), .dreq_data_o(dreq_data_o),
        .drsp_valid_i(drsp_valid_i), .drsp_ready_o(drsp_ready_o), .drsp_op_i(drsp_op_i),
        .drsp_err_i(drsp_err_i), .drsp_id_i(drsp_id_i), .drsp_data_i(drsp_data_i)
    );

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // Active lanes from the low address bits and size (R4).
    function automatic logic [3:0] lanes_of(input logic [1:0] size, input logic [1:0] lo);
        int cnt = 1 << size;
        logic [3:0] m = '0;
        for (int i = 0; i < 4; i++)
            if (i >= lo && i < lo + cnt) m[i] = 1'b1;
        return m;
    endfunction

    // Accepted mask set of R6.
    function automatic bit mask_listed(input logic [3:0] m);
        case (m)
            4'b0000, 4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011,
            4'b0110, 4'b1100, 4'b0111, 4'b1110, 4'b1111: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // First violated requirement number, or 0 for a legal request.
    function automatic int exp_rule(input logic [2:0] op, input logic [1:0] size,
                                    input logic [1:0] lo, input logic [3:0] mask);
        logic [3:0] act;
        if (!(op == 3'd0 || op == 3'd1 || op == 3'd4)) return 1;   // R1
        if (size > 2'd2) return 2;                                  // R2
        if ((int'(lo) % (1 << size)) != 0) return 3;                // R3
        act = lanes_of(size, lo);
        if ((mask & ~act) != 4'b0) return 4;                        // R4
        if (op == 3'd0 && (mask & act) != act) return 5;            // R5
        if (!mask_listed(mask)) return 6;                           // R6
        return 0;
    endfunction

    task automatic drive_req(input logic [2:0] op, input logic [1:0] size,
                             input logic [31:0] addr, input logic [3:0] mask,
                             input logic [7:0] id, input logic [31:0] data);
        hreq_valid_i = 1'b1;
        hreq_op_i = op; hreq_size_i = size; hreq_addr_i = addr;
        hreq_mask_i = mask; hreq_id_i = id; hreq_data_i = data;
    endtask

    // Drive one device response and check its pass-through (R10).
    task automatic dev_respond(input logic [7:0] id, input logic rd, input int hold);
        logic [31:0] d = $urandom;
        logic e = 1'($urandom % 2);
        drsp_valid_i = 1'b1; drsp_id_i = id; drsp_data_i = d; drsp_err_i = e;
        drsp_op_i = rd ? 3'd1 : 3'd0;
        hrsp_ready_i = 1'b0;
        for (int k = 0; k < hold; k++) begin
            #1;
            check(hrsp_valid_o && !drsp_ready_o, "R10 stall", {hrsp_valid_o, drsp_ready_o}, 2'b10);
            @(negedge clk);
        end
        hrsp_ready_i = 1'b1;
        #1;
        check(hrsp_valid_o && drsp_ready_o && hrsp_id_o == id && hrsp_data_o == d
              && hrsp_err_o == e && hrsp_op_o == drsp_op_i, "R10 passthru",
              {hrsp_valid_o, drsp_ready_o, hrsp_err_o, hrsp_op_o, hrsp_id_o, hrsp_data_o},
              {2'b11, e, drsp_op_i, id, d});
        @(negedge clk);
        drsp_valid_i = 1'b0; hrsp_ready_i = 1'b0;
    endtask

    // One full transaction starting from an idle guard.
    task automatic run_one(input logic [2:0] op, input logic [1:0] size,
                           input logic [31:0] addr, input logic [3:0] mask,
                           input logic [7:0] id, input int dly);
        int rule = exp_rule(op, size, addr[1:0], mask);
        string tag = (rule == 0) ? "R7" : $sformatf("R%0d", rule);
        logic [31:0] data = $urandom;
        @(negedge clk);
        drive_req(op, size, addr, mask, id, data);
        dreq_ready_i = 1'b0;
        #1;
        if (rule == 0) begin
            check(dreq_valid_o && {dreq_op_o, dreq_size_o, dreq_addr_o, dreq_mask_o,
                  dreq_id_o, dreq_data_o} == {op, size, addr, mask, id, data}, tag,
                  {dreq_valid_o, dreq_op_o, dreq_size_o, dreq_addr_o, dreq_mask_o, dreq_id_o, dreq_data_o},
                  {1'b1, op, size, addr, mask, id, data});
            check(!hreq_ready_o, "R7 ready follows device", hreq_ready_o, 1'b0);
            for (int k = 0; k < dly; k++) @(negedge clk);
            dreq_ready_i = 1'b1;
            #1;
            check(hreq_ready_o, "R7 ready follows device", hreq_ready_o, 1'b1);
            @(negedge clk);
            hreq_valid_i = 1'b0; dreq_ready_i = 1'b0;
            dev_respond(id, op == 3'd4, dly);
        end else begin
            check(!dreq_valid_o && hreq_ready_o, tag, {dreq_valid_o, hreq_ready_o}, 2'b01);
            check(!hrsp_valid_o, "R9 no same-cycle error", hrsp_valid_o, 1'b0);
            @(negedge clk);
            drive_req(3'd4, 2'd2, 32'h0, 4'hf, 8'hee, 32'h0);
            #1;
            check(!hreq_ready_o && !dreq_valid_o, "R9 blocked", {hreq_ready_o, dreq_valid_o}, 2'b00);
            hreq_valid_i = 1'b0;
            for (int k = 0; k <= dly; k++) begin
                #1;
                check(hrsp_valid_o && hrsp_err_o && hrsp_id_o == id && hrsp_data_o == 32'h0
                      && hrsp_op_o == (op == 3'd4 ? 3'd1 : 3'd0), "R8 error response",
                      {hrsp_valid_o, hrsp_err_o, hrsp_op_o, hrsp_id_o, hrsp_data_o},
                      {2'b11, (op == 3'd4 ? 3'd1 : 3'd0), id, 32'h0});
                if (k == dly) hrsp_ready_i = 1'b1;
                @(negedge clk);
            end
            hrsp_ready_i = 1'b0;
            #1;
            check(!hrsp_valid_o, "R8 single response", hrsp_valid_o, 1'b0);
        end
    endtask

    initial begin
        logic [2:0] op;
        logic [1:0] size;
        logic [31:0] addr;
        logic [3:0] mask;
        void'($urandom(32'h1a2b3c4d));
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        #1;
        // R12 reset state
        check(!hrsp_valid_o && !dreq_valid_o, "R12 reset", {hrsp_valid_o, dreq_valid_o}, 2'b00);

        // Directed corner cases.
        run_one(3'd1, 2'd2, 32'h100, 4'b1001, 8'h01, 1);   // R6 gap
        run_one(3'd4, 2'd2, 32'h104, 4'b0101, 8'h02, 0);   // R6 gap
        run_one(3'd0, 2'd1, 32'h102, 4'b1100, 8'h03, 0);   // R7 legal half write
        run_one(3'd0, 2'd1, 32'h102, 4'b0100, 8'h04, 1);   // R5 missing lane
        run_one(3'd4, 2'd1, 32'h101, 4'b0110, 8'h05, 0);   // R3 misaligned
        run_one(3'd4, 2'd3, 32'h100, 4'b1111, 8'h06, 0);   // R2 oversize
        run_one(3'd7, 2'd2, 32'h100, 4'b1111, 8'h07, 0);   // R1 bad opcode
        run_one(3'd2, 2'd2, 32'h100, 4'b1111, 8'h08, 2);   // R1 bad opcode
        run_one(3'd4, 2'd0, 32'h103, 4'b1000, 8'h09, 0);   // R7 legal byte read
        run_one(3'd4, 2'd0, 32'h103, 4'b0001, 8'h0a, 0);   // R4 wrong lane
        run_one(3'd1, 2'd2, 32'h100, 4'b0000, 8'h0b, 0);   // R6 empty mask allowed

        // Random mix.
        for (int n = 0; n < 300; n++) begin
            int r = $urandom % 8;
            if (r < 3) op = 3'd0;
            else if (r < 5) op = 3'd1;
            else if (r < 7) op = 3'd4;
            else begin
                int u = $urandom % 5;
                op = (u == 0) ? 3'd2 : (u == 1) ? 3'd3 : (u == 2) ? 3'd5 : (u == 3) ? 3'd6 : 3'd7;
            end
            size = ($urandom % 8 == 0) ? 2'd3 : 2'($urandom % 3);
            addr = $urandom;
            if ($urandom % 4 != 0 && size != 2'd3)
                addr[1:0] = addr[1:0] & ~2'((1 << size) - 1);
            r = $urandom % 4;
            if (size == 2'd3 || r == 0) mask = 4'($urandom);
            else if (r == 3) mask = lanes_of(size, addr[1:0]) & 4'($urandom);
            else mask = lanes_of(size, addr[1:0]);
            run_one(op, size, addr, mask, 8'($urandom), int'($urandom % 3));
        end

        // R10: error waits behind two outstanding reads.
        @(negedge clk);
        dreq_ready_i = 1'b1;
        drive_req(3'd4, 2'd2, 32'h200, 4'hf, 8'h10, 32'h0);
        @(negedge clk);
        drive_req(3'd4, 2'd2, 32'h204, 4'hf, 8'h11, 32'h0);
        @(negedge clk);
        drive_req(3'd6, 2'd2, 32'h208, 4'hf, 8'h22, 32'h0);
        #1;
        check(hreq_ready_o && !dreq_valid_o, "R10 illegal absorbed", {hreq_ready_o, dreq_valid_o}, 2'b10);
        @(negedge clk);
        hreq_valid_i = 1'b0; dreq_ready_i = 1'b0; hrsp_ready_i = 1'b1;
        for (int k = 0; k < 3; k++) begin
            #1;
            check(!hrsp_valid_o, "R10 error held back", hrsp_valid_o, 1'b0);
            @(negedge clk);
        end
        dev_respond(8'h10, 1'b1, 0);
        dev_respond(8'h11, 1'b1, 0);
        #1;
        check(hrsp_valid_o && hrsp_err_o && hrsp_id_o == 8'h22, "R10 error after drain",
              {hrsp_valid_o, hrsp_err_o, hrsp_id_o}, {2'b11, 8'h22});
        hrsp_ready_i = 1'b1;
        @(negedge clk);
        hrsp_ready_i = 1'b0;

        // R11: outstanding limit.
        dreq_ready_i = 1'b1;
        for (int k = 0; k < 4; k++) begin
            drive_req(3'd4, 2'd2, 32'h300, 4'hf, 8'(8'h30 + k), 32'h0);
            @(negedge clk);
        end
        drive_req(3'd4, 2'd2, 32'h300, 4'hf, 8'h34, 32'h0);
        #1;
        check(!dreq_valid_o && !hreq_ready_o, "R11 limit stalls", {dreq_valid_o, hreq_ready_o}, 2'b00);
        drsp_valid_i = 1'b1; drsp_id_i = 8'h30; drsp_op_i = 3'd1; drsp_err_i = 1'b0;
        hrsp_ready_i = 1'b1;
        @(negedge clk);
        drsp_valid_i = 1'b0; hrsp_ready_i = 1'b0;
        #1;
        check(dreq_valid_o && dreq_id_o == 8'h34 && hreq_ready_o, "R11 slot freed",
              {dreq_valid_o, hreq_ready_o, dreq_id_o}, {2'b11, 8'h34});
        @(negedge clk);
        hreq_valid_i = 1'b0; dreq_ready_i = 1'b0;
        for (int k = 1; k < 5; k++) dev_respond(8'(8'h30 + k), 1'b1, 0);

        // R12: reset clears a pending error.
        @(negedge clk);
        drive_req(3'd5, 2'd2, 32'h0, 4'hf, 8'h55, 32'h0);
        @(negedge clk);
        hreq_valid_i = 1'b0;
        #1;
        check(hrsp_valid_o, "R12 error pending before reset", hrsp_valid_o, 1'b1);
        rst_ni = 1'b0;
        @(negedge clk);
        rst_ni = 1'b1;
        #1;
        check(!hrsp_valid_o && !dreq_valid_o, "R12 cleared", {hrsp_valid_o, dreq_valid_o}, 2'b00);
        @(negedge clk);
        finish_run();
    end

endmodule